// File: doc/BRIEF.md
# BCD Time and Calendar Counter

This block keeps wall-clock time and the calendar date as packed BCD fields: seconds, minutes, hours, a three-bit weekday code, day of month, month and a two-digit year standing for 2000 to 2099. It advances by one second on each cycle where a one-pulse-per-second enable is seen. A ripple of carries moves the count through the minutes, hours, days, months and years, with month lengths and leap Februaries taken into account. The hour field is read either as 00 to 23, or as 12, 01 to 11 with a PM flag.

Software sets the time through a small write port that addresses one field per write. Each write raises a restart pulse so that an external sub-second divider can start a fresh second. A hold input lets a reader freeze the fields while it samples them. A tick that arrives during hold is kept and applied once hold drops. An adjust strobe rounds the seconds to the nearest minute, so a clock can be brought into line against a time signal.

Top module: `bcd_calendar_counter`

## Requirements
- R1: The seconds field (7 bits, BCD) advances 00..59 on each applied tick. From 59 it returns to 00 and gives a carry into minutes; otherwise minutes stay unchanged.
- R2: The minutes field (7 bits, BCD) advances 00..59 on each seconds carry. From 59 it returns to 00 and gives a carry into hours.
- R3: With mode_24h high, the hour field (6 bits, BCD) runs 00..23 on each minutes carry. From 23 it returns to 00 and gives a day carry.
- R4: With mode_24h low, hour bits 4:0 hold a BCD hour in the order 12, 01, ..., 11 and bit 5 is the PM flag (1 = PM). Going from 11 to 12 toggles the flag, and 11 PM to 12 AM gives a day carry. A 12 becomes 01 with the flag kept.
- R5: The weekday field (3 bits) steps by one on each day carry, 0 through 6, then back to 0. A value of 0..6 never leaves that range without a write.
- R6: The day of month (6 bits, BCD) runs from 01 to the month's last day, then returns to 01 with a month carry. Months 04, 06, 09 and 11 end on 30, and February ends on 29 when the BCD year is a multiple of four and on 28 otherwise. Every other month ends on 31. Month (5 bits, BCD) runs 01..12, then back to 01 with a year carry. Year (8 bits, BCD) runs 00..99, then back to 00.
- R7: A write with wr_en high loads wr_data, truncated to the field's width, into the field chosen by wr_addr: 0 seconds, 1 minutes, 2 hour, 3 weekday, 4 day, 5 month, 6 year. Address 7 changes nothing. The new value shows on the cycle after the write. A write takes priority over an adjust and a tick in the same cycle, drops that tick, and drops any held tick.
- R8: sub_sec_restart is high for exactly the one cycle that follows each write cycle, and low otherwise.
- R9: While hold is high, ticks do not advance any field. If one or more ticks arrive during hold, exactly one step is applied in the first cycle with hold low.
- R10: An adjust strobe (without a write) sets seconds to 00. If seconds were 30..59, a carry goes into minutes and ripples on as an ordinary carry would. If seconds were 00..29, no carry is made. A tick in the same cycle as an adjust is applied in the next free cycle.
- R11: After reset, the fields read 00:00:00, weekday 0, day 01, month 01, year 00, and sub_sec_restart is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| hold | input | 1 | Freezes counting; ticks during hold are deferred |
| mode_24h | input | 1 | 1 = 24-hour hour field, 0 = 12-hour with PM flag |
| adj_strobe | input | 1 | Round seconds to the nearest minute |
| wr_en | input | 1 | Field write enable |
| wr_addr | input | 3 | Field select for a write |
| wr_data | input | 8 | BCD value to write |
| sec_o | output | 7 | Seconds, BCD |
| min_o | output | 7 | Minutes, BCD |
| hour_o | output | 6 | Hour, BCD (bit 5 = PM in 12-hour mode) |
| wday_o | output | 3 | Weekday code 0..6 |
| day_o | output | 6 | Day of month, BCD |
| month_o | output | 5 | Month, BCD |
| year_o | output | 8 | Year within the century, BCD |
| sub_sec_restart | output | 1 | One-cycle pulse after each write |

## Verification
Directed cases place the count one second before each kind of rollover: minute, hour, end of day in both hour formats, the ends of 30- and 31-day months, February in leap and common years, and the end of the century. This separates the carry paths from one another. The adjust is tried just below and just at 30 seconds, and on 23:59:45, which separates the no-carry case, a minute carry and a full-day ripple. A randomized stream mixes ticks, hold windows, adjusts and writes of field values near their limits in both hour modes. This exposes ordering mistakes between write, adjust, held ticks and new ticks, which a bench-side model of the rules catches.

// File: rtl/cal_pkg.sv
// Shared widths, field selector encoding and BCD helper functions for the
// calendar counter. Assumes all counted values are packed two-digit BCD.
package cal_pkg;

    localparam int SEC_W  = 7;
    localparam int MIN_W  = 7;
    localparam int HOUR_W = 6;
    localparam int WDAY_W = 3;
    localparam int DAY_W  = 6;
    localparam int MON_W  = 5;
    localparam int YEAR_W = 8;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;

    localparam logic [WDAY_W-1:0] WDAY_LAST = 3'd6;

    typedef enum logic [ADDR_W-1:0] {
        FLD_SEC  = 3'd0,
        FLD_MIN  = 3'd1,
        FLD_HOUR = 3'd2,
        FLD_WDAY = 3'd3,
        FLD_DAY  = 3'd4,
        FLD_MON  = 3'd5,
        FLD_YEAR = 3'd6,
        FLD_NONE = 3'd7
    } field_sel_e;

    // Next BCD value of a two-digit number (no range wrap applied here).
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        logic [7:0] r;
        if (v[3:0] >= 4'd9) begin
            r = {v[7:4] + 4'd1, 4'd0};
        end else begin
            r = v + 8'd1;
        end
        return r;
    endfunction

    // A BCD year is a multiple of four when (2*tens + units) mod 4 is zero.
    function automatic logic leap_year(input logic [7:0] y);
        logic [1:0] s;
        s = {y[4], 1'b0} + y[1:0];
        return (s == 2'b00);
    endfunction

    // Last day of a BCD month.
    function automatic logic [5:0] month_end(input logic [4:0] m, input logic leap);
        logic [5:0] r;
        case (m)
            5'h02:                      r = leap ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: r = 6'h30;
            default:                    r = 6'h31;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cal_step_ctrl.sv
// Decides, cycle by cycle, whether the counter steps, adjusts or takes a write.
// Priority is write, then adjust, then tick. Ticks seen while hold is high or
// while an adjust is taken are remembered as one pending step.
module cal_step_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic hold,
    input  logic wr_en,
    input  logic adj_req,
    output logic step,
    output logic adj_go,
    output logic restart
);
    logic pend_q;
    logic restart_q;

    assign adj_go  = adj_req & ~wr_en;
    assign step    = (tick | pend_q) & ~hold & ~wr_en & ~adj_go;
    assign restart = restart_q;

    // Keep one deferred tick across hold or adjust cycles; a write discards it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (wr_en) begin
            pend_q <= 1'b0;
        end else if (hold || adj_go) begin
            pend_q <= pend_q | tick;
        end else begin
            pend_q <= 1'b0;
        end
    end

    // Pulse the sub-second restart in the cycle after a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            restart_q <= 1'b0;
        end else begin
            restart_q <= wr_en;
        end
    end
endmodule

// File: rtl/cal_clock_chain.sv
// Seconds, minutes and hour registers with their carries. The hour field is
// read as 24-hour or as 12-hour with a PM flag in bit 5, according to
// mode_24h; a change of mode does not convert the stored hour.
module cal_clock_chain
    import cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              adj_go,
    input  logic              wr_en,
    input  field_sel_e        wr_sel,
    input  logic [SEC_W-1:0]  wr_data,
    input  logic              mode_24h,
    output logic [SEC_W-1:0]  sec_o,
    output logic [MIN_W-1:0]  min_o,
    output logic [HOUR_W-1:0] hour_o,
    output logic              day_carry
);
    logic [SEC_W-1:0]  sec_q, sec_inc;
    logic [MIN_W-1:0]  min_q, min_inc;
    logic [HOUR_W-1:0] hour_q, hour_adv, h24_inc;
    logic [4:0]        h12_inc;
    logic              sec_wrap, sec_carry, min_wrap, min_carry, hour_roll;

    assign sec_inc = SEC_W'(bcd_inc({1'b0, sec_q}));
    assign min_inc = MIN_W'(bcd_inc({1'b0, min_q}));
    assign h24_inc = HOUR_W'(bcd_inc({2'b00, hour_q}));
    assign h12_inc = 5'(bcd_inc({3'b000, hour_q[4:0]}));

    // Carry generation for seconds and minutes, including the adjust round-up.
    always_comb begin
        sec_wrap  = (sec_q == 7'h59);
        sec_carry = (step & sec_wrap) | (adj_go & (sec_q >= 7'h30));
        min_wrap  = (min_q == 7'h59);
        min_carry = sec_carry & min_wrap;
    end

    // Next hour value and end-of-day detection for both hour formats.
    always_comb begin
        hour_roll = 1'b0;
        if (mode_24h) begin
            if (hour_q >= 6'h23) begin
                hour_adv  = '0;
                hour_roll = 1'b1;
            end else begin
                hour_adv = h24_inc;
            end
        end else begin
            if (hour_q[4:0] == 5'h11) begin
                hour_adv  = {~hour_q[5], 5'h12};
                hour_roll = hour_q[5];
            end else if (hour_q[4:0] >= 5'h12) begin
                hour_adv = {hour_q[5], 5'h01};
            end else begin
                hour_adv = {hour_q[5], h12_inc};
            end
        end
    end

    assign day_carry = min_carry & hour_roll;

    // Seconds register: write, adjust clear, or count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q <= '0;
        end else if (wr_en && wr_sel == FLD_SEC) begin
            sec_q <= wr_data;
        end else if (adj_go) begin
            sec_q <= '0;
        end else if (step) begin
            sec_q <= sec_wrap ? '0 : sec_inc;
        end
    end

    // Minutes register: write or advance on seconds carry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            min_q <= '0;
        end else if (wr_en && wr_sel == FLD_MIN) begin
            min_q <= wr_data;
        end else if (sec_carry) begin
            min_q <= min_wrap ? '0 : min_inc;
        end
    end

    // Hour register: write or advance on minutes carry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hour_q <= '0;
        end else if (wr_en && wr_sel == FLD_HOUR) begin
            hour_q <= wr_data[HOUR_W-1:0];
        end else if (min_carry) begin
            hour_q <= hour_adv;
        end
    end

    assign sec_o  = sec_q;
    assign min_o  = min_q;
    assign hour_o = hour_q;
endmodule

// File: rtl/cal_date_chain.sv
// Weekday, day, month and year registers advanced by the day carry. Month
// lengths follow the BCD month and a divisible-by-four leap rule, which is
// exact for years 2000 to 2099. Out-of-range written values wrap at the next
// carry.
module cal_date_chain
    import cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              day_carry,
    input  logic              wr_en,
    input  field_sel_e        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [WDAY_W-1:0] wday_o,
    output logic [DAY_W-1:0]  day_o,
    output logic [MON_W-1:0]  month_o,
    output logic [YEAR_W-1:0] year_o
);
    logic [WDAY_W-1:0] wday_q;
    logic [DAY_W-1:0]  day_q, day_inc, day_last;
    logic [MON_W-1:0]  mon_q, mon_inc;
    logic [YEAR_W-1:0] year_q, year_inc;
    logic              day_wrap, mon_wrap, year_wrap, mon_carry, year_carry;

    assign day_inc  = DAY_W'(bcd_inc({2'b00, day_q}));
    assign mon_inc  = MON_W'(bcd_inc({3'b000, mon_q}));
    assign year_inc = bcd_inc(year_q);

    // End-of-period detection along the date ripple.
    always_comb begin
        day_last   = month_end(mon_q, leap_year(year_q));
        day_wrap   = (day_q >= day_last);
        mon_wrap   = (mon_q >= 5'h12);
        year_wrap  = (year_q >= 8'h99);
        mon_carry  = day_carry & day_wrap;
        year_carry = mon_carry & mon_wrap;
    end

    // Weekday register: septimal count on each day carry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wday_q <= '0;
        end else if (wr_en && wr_sel == FLD_WDAY) begin
            wday_q <= wr_data[WDAY_W-1:0];
        end else if (day_carry) begin
            wday_q <= (wday_q >= WDAY_LAST) ? '0 : wday_q + 3'd1;
        end
    end

    // Day-of-month register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            day_q <= 6'h01;
        end else if (wr_en && wr_sel == FLD_DAY) begin
            day_q <= wr_data[DAY_W-1:0];
        end else if (day_carry) begin
            day_q <= day_wrap ? 6'h01 : day_inc;
        end
    end

    // Month register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mon_q <= 5'h01;
        end else if (wr_en && wr_sel == FLD_MON) begin
            mon_q <= wr_data[MON_W-1:0];
        end else if (mon_carry) begin
            mon_q <= mon_wrap ? 5'h01 : mon_inc;
        end
    end

    // Year register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            year_q <= '0;
        end else if (wr_en && wr_sel == FLD_YEAR) begin
            year_q <= wr_data;
        end else if (year_carry) begin
            year_q <= year_wrap ? '0 : year_inc;
        end
    end

    assign wday_o  = wday_q;
    assign day_o   = day_q;
    assign month_o = mon_q;
    assign year_o  = year_q;
endmodule

// File: rtl/bcd_calendar_counter.sv
// Top of the BCD time and calendar counter. Takes a once-per-second enable,
// a per-field write port, hold and adjust controls, and presents every count
// field. Assumes tick_1hz is a single-cycle pulse synchronous to clk.
module bcd_calendar_counter
    import cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              hold,
    input  logic              mode_24h,
    input  logic              adj_strobe,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [SEC_W-1:0]  sec_o,
    output logic [MIN_W-1:0]  min_o,
    output logic [HOUR_W-1:0] hour_o,
    output logic [WDAY_W-1:0] wday_o,
    output logic [DAY_W-1:0]  day_o,
    output logic [MON_W-1:0]  month_o,
    output logic [YEAR_W-1:0] year_o,
    output logic              sub_sec_restart
);
    logic       step, adj_go, day_carry;
    field_sel_e wr_sel;

    assign wr_sel = field_sel_e'(wr_addr);

    cal_step_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_1hz),
        .hold    (hold),
        .wr_en   (wr_en),
        .adj_req (adj_strobe),
        .step    (step),
        .adj_go  (adj_go),
        .restart (sub_sec_restart)
    );

    cal_clock_chain u_clock (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .adj_go    (adj_go),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data[SEC_W-1:0]),
        .mode_24h  (mode_24h),
        .sec_o     (sec_o),
        .min_o     (min_o),
        .hour_o    (hour_o),
        .day_carry (day_carry)
    );

    cal_date_chain u_date (
        .clk       (clk),
        .rst_n     (rst_n),
        .day_carry (day_carry),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .wday_o    (wday_o),
        .day_o     (day_o),
        .month_o   (month_o),
        .year_o    (year_o)
    );
endmodule

// File: rtl/cal_counter_checker.sv
// Temporal checks on the calendar counter ports, bound to the top module.
module cal_counter_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_1hz,
    input logic       hold,
    input logic       adj_strobe,
    input logic       wr_en,
    input logic [2:0] wr_addr,
    input logic [7:0] wr_data,
    input logic [6:0] sec_o,
    input logic [6:0] min_o,
    input logic [5:0] hour_o,
    input logic [2:0] wday_o,
    input logic [5:0] day_o,
    input logic [4:0] month_o,
    input logic [7:0] year_o,
    input logic       sub_sec_restart
);
    assert_no_carry_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1hz && !hold && !wr_en && !adj_strobe && sec_o != 7'h59) |=> $stable(min_o));

    assert_wday_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && wday_o <= 3'd6) |=> (wday_o <= 3'd6));

    assert_day_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && day_o != 6'h00 && day_o <= 6'h31) |=> (day_o != 6'h00));

    assert_write_sec_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd0) |=> (sec_o == $past(wr_data[6:0])));

    assert_write_year_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd6) |=> (year_o == $past(wr_data)));

    assert_restart_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> sub_sec_restart);

    assert_restart_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !sub_sec_restart);

    assert_hold_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !wr_en && !adj_strobe) |=> ($stable(sec_o) && $stable(min_o) &&
            $stable(hour_o) && $stable(wday_o) && $stable(day_o) &&
            $stable(month_o) && $stable(year_o)));

    assert_adjust_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (adj_strobe && !wr_en) |=> (sec_o == 7'h00));
endmodule

bind bcd_calendar_counter cal_counter_checker u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .tick_1hz        (tick_1hz),
    .hold            (hold),
    .adj_strobe      (adj_strobe),
    .wr_en           (wr_en),
    .wr_addr         (wr_addr),
    .wr_data         (wr_data),
    .sec_o           (sec_o),
    .min_o           (min_o),
    .hour_o          (hour_o),
    .wday_o          (wday_o),
    .day_o           (day_o),
    .month_o         (month_o),
    .year_o          (year_o),
    .sub_sec_restart (sub_sec_restart)
);

// File: tb/bcd_calendar_counter_tb.sv
module bcd_calendar_counter_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0, hold = 1'b0, mode_24h = 1'b1, adj_strobe = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic [6:0] sec_o, min_o;
    logic [5:0] hour_o, day_o;
    logic [2:0] wday_o;
    logic [4:0] month_o;
    logic [7:0] year_o;
    logic       sub_sec_restart;

    int  n_chk = 0, n_err = 0;
    bit  done = 0;

    // Bench model state
    logic [6:0] m_sec, m_min;
    logic [5:0] m_hour, m_day;
    logic [2:0] m_wday;
    logic [4:0] m_mon;
    logic [7:0] m_year;
    logic       m_pend, m_rst;

    always #10 clk = ~clk;

    bcd_calendar_counter u_dut (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .hold(hold),
        .mode_24h(mode_24h), .adj_strobe(adj_strobe), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .sec_o(sec_o), .min_o(min_o),
        .hour_o(hour_o), .wday_o(wday_o), .day_o(day_o), .month_o(month_o),
        .year_o(year_o), .sub_sec_restart(sub_sec_restart)
    );

    function automatic int b2i(input logic [7:0] v);
        return int'(v[7:4]) * 10 + int'(v[3:0]);
    endfunction

    function automatic logic [7:0] i2b(input int n);
        return {4'(n / 10), 4'(n % 10)};
    endfunction

    function automatic int days_in(input int mo, input int yr);
        case (mo)
            2: return (yr % 4 == 0) ? 29 : 28;
            4, 6, 9, 11: return 30;
            default: return 31;
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        check({tag, " sec"}, sec_o, m_sec);
        check({tag, " min"}, min_o, m_min);
        check({tag, " hour"}, hour_o, m_hour);
        check({tag, " wday"}, wday_o, m_wday);
        check({tag, " day"}, day_o, m_day);
        check({tag, " month"}, month_o, m_mon);
        check({tag, " year"}, year_o, m_year);
        check({tag, " restart"}, sub_sec_restart, m_rst);
    endtask

    task automatic m_next_month();
        int mo, yr;
        mo = b2i({3'b0, m_mon});
        if (mo >= 12) begin
            m_mon = 5'h01;
            yr = b2i(m_year);
            m_year = i2b(yr >= 99 ? 0 : yr + 1);
        end else m_mon = 5'(i2b(mo + 1));
    endtask

    task automatic m_next_day();
        int d;
        m_wday = (m_wday >= 3'd6) ? 3'd0 : m_wday + 3'd1;
        d = b2i({2'b0, m_day});
        if (d >= days_in(b2i({3'b0, m_mon}), b2i(m_year))) begin
            m_day = 6'h01;
            m_next_month();
        end else m_day = 6'(i2b(d + 1));
    endtask

    task automatic m_next_hour();
        int h;
        logic pm;
        if (mode_24h) begin
            h = b2i({2'b0, m_hour});
            if (h >= 23) begin m_hour = 6'h00; m_next_day(); end
            else m_hour = 6'(i2b(h + 1));
        end else begin
            h = b2i({3'b0, m_hour[4:0]});
            pm = m_hour[5];
            if (h == 11) begin
                m_hour = {~pm, 5'h12};
                if (pm) m_next_day();
            end else if (h >= 12) m_hour = {pm, 5'h01};
            else m_hour = {pm, 5'(i2b(h + 1))};
        end
    endtask

    task automatic m_next_min();
        int mi;
        mi = b2i({1'b0, m_min});
        if (mi >= 59) begin m_min = 7'h00; m_next_hour(); end
        else m_min = 7'(i2b(mi + 1));
    endtask

    task automatic m_next_sec();
        int s;
        s = b2i({1'b0, m_sec});
        if (s >= 59) begin m_sec = 7'h00; m_next_min(); end
        else m_sec = 7'(i2b(s + 1));
    endtask

    // One clock cycle: drive at the falling edge, model at the rising edge,
    // compare at the next falling edge.
    task automatic cyc(input bit t, input bit h, input bit w, input logic [2:0] a,
                       input logic [7:0] d, input bit j, input string tag);
        bit up;
        tick_1hz = t; hold = h; wr_en = w; wr_addr = a; wr_data = d; adj_strobe = j;
        @(posedge clk);
        if (w) begin
            case (a)
                3'd0: m_sec  = d[6:0];
                3'd1: m_min  = d[6:0];
                3'd2: m_hour = d[5:0];
                3'd3: m_wday = d[2:0];
                3'd4: m_day  = d[5:0];
                3'd5: m_mon  = d[4:0];
                3'd6: m_year = d;
                default: ;
            endcase
            m_pend = 0;
            m_rst = 1;
        end else begin
            m_rst = 0;
            if (j) begin
                up = b2i({1'b0, m_sec}) >= 30;
                m_sec = 7'h00;
                if (up) m_next_min();
                m_pend = m_pend | t;
            end else if (h) begin
                m_pend = m_pend | t;
            end else if (t || m_pend) begin
                m_pend = 0;
                m_next_sec();
            end
        end
        @(negedge clk);
        compare_all(tag);
        tick_1hz = 0; hold = 0; wr_en = 0; adj_strobe = 0;
    endtask

    task automatic set_all(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                           input logic [7:0] wd, input logic [7:0] d, input logic [7:0] mo,
                           input logic [7:0] y);
        cyc(0, 0, 1, 3'd0, s, 0, "R7 set");
        cyc(0, 0, 1, 3'd1, mi, 0, "R7 set");
        cyc(0, 0, 1, 3'd2, h, 0, "R7 set");
        cyc(0, 0, 1, 3'd3, wd, 0, "R7 set");
        cyc(0, 0, 1, 3'd4, d, 0, "R7 set");
        cyc(0, 0, 1, 3'd5, mo, 0, "R7 set");
        cyc(0, 0, 1, 3'd6, y, 0, "R7 set");
        cyc(0, 0, 0, 3'd0, 8'h00, 0, "R8 idle");
    endtask

    function automatic int pick(input int n);
        return ($urandom_range(1, 0) == 1) ? n - 1 : int'($urandom_range(n - 1, 0));
    endfunction

    function automatic logic [7:0] rnd_val(input logic [2:0] a);
        case (a)
            3'd0: return i2b(pick(60));
            3'd1: return i2b(pick(60));
            3'd2: return mode_24h ? i2b(pick(24))
                                  : {2'b00, 1'($urandom_range(1, 0)), 5'(i2b(pick(12) % 12 == 0 ? 11 : pick(12) + 1))};
            3'd3: return 8'(pick(7));
            3'd4: return i2b(1 + pick(days_in(b2i({3'b0, m_mon}), b2i(m_year))));
            3'd5: return i2b(1 + pick(12));
            default: return i2b(pick(100));
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        m_sec = 0; m_min = 0; m_hour = 0; m_wday = 0; m_day = 6'h01;
        m_mon = 5'h01; m_year = 0; m_pend = 0; m_rst = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        compare_all("R11 reset");
        check("R11 day", day_o, 6'h01);
        check("R11 month", month_o, 5'h01);

        // R1 second count and minute carry
        set_all(8'h58, 8'h00, 8'h10, 8'h02, 8'h15, 8'h06, 8'h30);
        cyc(1, 0, 0, 0, 0, 0, "R1 tick");
        check("R1 sec 59", sec_o, 7'h59);
        cyc(1, 0, 0, 0, 0, 0, "R1 wrap");
        check("R1 min carry", min_o, 7'h01);
        // R2 minute to hour
        set_all(8'h59, 8'h59, 8'h05, 8'h02, 8'h15, 8'h06, 8'h30);
        cyc(1, 0, 0, 0, 0, 0, "R2 wrap");
        check("R2 hour", hour_o, 6'h06);
        // R3 R5 R6 end of day into leap February 29
        set_all(8'h59, 8'h59, 8'h23, 8'h06, 8'h28, 8'h02, 8'h24);
        cyc(1, 0, 0, 0, 0, 0, "R3 day end");
        check("R3 hour", hour_o, 6'h00);
        check("R5 wday wrap", wday_o, 3'd0);
        check("R6 leap feb29", day_o, 6'h29);
        set_all(8'h59, 8'h59, 8'h23, 8'h00, 8'h29, 8'h02, 8'h24);
        cyc(1, 0, 0, 0, 0, 0, "R6 leap end");
        check("R6 leap to mar", month_o, 5'h03);
        set_all(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h23);
        cyc(1, 0, 0, 0, 0, 0, "R6 common feb");
        check("R6 common feb day", day_o, 6'h01);
        set_all(8'h59, 8'h59, 8'h23, 8'h03, 8'h30, 8'h04, 8'h23);
        cyc(1, 0, 0, 0, 0, 0, "R6 april end");
        check("R6 may", month_o, 5'h05);
        set_all(8'h59, 8'h59, 8'h23, 8'h03, 8'h31, 8'h12, 8'h99);
        cyc(1, 0, 0, 0, 0, 0, "R6 century");
        check("R6 year wrap", year_o, 8'h00);
        check("R6 jan", month_o, 5'h01);

        // R4 twelve-hour mode
        mode_24h = 1'b0;
        set_all(8'h59, 8'h59, 8'h31, 8'h01, 8'h10, 8'h07, 8'h40);
        cyc(1, 0, 0, 0, 0, 0, "R4 pm to am");
        check("R4 12am", hour_o, 6'h12);
        check("R4 day carry", day_o, 6'h11);
        set_all(8'h59, 8'h59, 8'h11, 8'h01, 8'h10, 8'h07, 8'h40);
        cyc(1, 0, 0, 0, 0, 0, "R4 am to pm");
        check("R4 12pm", hour_o, 6'h32);
        set_all(8'h59, 8'h59, 8'h32, 8'h01, 8'h10, 8'h07, 8'h40);
        cyc(1, 0, 0, 0, 0, 0, "R4 12 to 1");
        check("R4 1pm", hour_o, 6'h21);
        mode_24h = 1'b1;
        cyc(0, 0, 1, 3'd2, 8'h08, 0, "R7 hour");

        // R10 adjust
        cyc(0, 0, 1, 3'd1, 8'h10, 0, "R7 min");
        cyc(0, 0, 1, 3'd0, 8'h29, 0, "R7 sec");
        cyc(0, 0, 0, 0, 0, 1, "R10 round down");
        check("R10 min kept", min_o, 7'h10);
        cyc(0, 0, 1, 3'd0, 8'h30, 0, "R7 sec");
        cyc(0, 0, 0, 0, 0, 1, "R10 round up");
        check("R10 min up", min_o, 7'h11);
        cyc(0, 0, 1, 3'd0, 8'h45, 0, "R7 sec");
        cyc(1, 0, 0, 0, 0, 1, "R10 adjust with tick");
        check("R10 sec zero", sec_o, 7'h00);
        cyc(0, 0, 0, 0, 0, 0, "R10 deferred tick");
        check("R10 deferred", sec_o, 7'h01);
        set_all(8'h45, 8'h59, 8'h23, 8'h04, 8'h31, 8'h12, 8'h50);
        cyc(0, 0, 0, 0, 0, 1, "R10 full ripple");
        check("R10 ripple year", year_o, 8'h51);

        // R9 hold
        cyc(0, 0, 1, 3'd0, 8'h10, 0, "R7 sec");
        cyc(1, 1, 0, 0, 0, 0, "R9 hold");
        cyc(1, 1, 0, 0, 0, 0, "R9 hold");
        cyc(1, 1, 0, 0, 0, 0, "R9 hold");
        check("R9 frozen", sec_o, 7'h10);
        cyc(0, 0, 0, 0, 0, 0, "R9 release");
        check("R9 one step", sec_o, 7'h11);
        cyc(0, 0, 0, 0, 0, 0, "R9 no more");
        check("R9 single", sec_o, 7'h11);

        // R7 R8 write priority, ignored address, restart pulse
        cyc(1, 0, 1, 3'd0, 8'h20, 1, "R7 write wins");
        check("R7 written", sec_o, 7'h20);
        check("R8 pulse", sub_sec_restart, 1);
        cyc(0, 0, 0, 0, 0, 0, "R7 tick dropped");
        check("R7 still", sec_o, 7'h20);
        check("R8 pulse end", sub_sec_restart, 0);
        cyc(0, 0, 1, 3'd7, 8'h55, 0, "R7 address 7 ignored");

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            int r;
            logic [2:0] a;
            if (i == 2000) begin
                mode_24h = 1'b0;
                cyc(0, 0, 1, 3'd2, rnd_val(3'd2), 0, "R4 mode");
            end
            r = $urandom_range(99, 0);
            if (r < 5) begin
                a = 3'($urandom_range(6, 0));
                cyc($urandom_range(1, 0) == 1, 0, 1, a, rnd_val(a), 0, "R7 random");
            end else begin
                cyc($urandom_range(2, 0) != 0, $urandom_range(9, 0) == 0, 0, 3'd0, 8'h00,
                    $urandom_range(49, 0) == 0, "R1 random");
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule